// File: doc/BRIEF.md
# Attenuator DAC-Code Controller

This block sets the 10-bit code of an on-chip control DAC that steers a pair of analog attenuators. A host programs it over a 4-wire SPI slave port that holds a direct code, an increment size and a decrement size. A plain mode input picks where the code comes from. In direct mode the code tracks the direct register. In step mode the code moves up or down by the programmed sizes on each rising edge of two external pulse inputs, so no further SPI traffic is needed.

All SPI and pulse inputs are asynchronous to the block clock. They pass through two-flop synchronizers before edge detection, so the block clock must run several times faster than SCLK. A pair of plain select inputs is decoded into the enable and routing controls for the DAC, the comparator switch and the control-pin driver. The analog parts are outside this block.

Top module: `att_dac_ctrl`

## Requirements
- R1: A frame is clocked in MSB first on SCLK rising edges while CS is low. The first bit is the access type (1 = read, 0 = write), the next two bits are the register address, and the last ten bits are data.
- R2: A write takes effect when CS rises, and only if exactly 13 bits were clocked. A shorter or longer frame changes no register.
- R3: Address 0 is the direct code, address 1 the increment, address 2 the decrement, and address 3 reads back the live DAC code. A write to address 3 has no effect.
- R4: In a read frame, the addressed register's ten bits appear MSB first on MISO during the data phase, changing after SCLK falling edges. The read frame alters no register. MISO is low while CS is high.
- R5: With mode_step low, dac_code takes the direct register value one clock later, and step_up and step_dn have no effect.
- R6: With mode_step high, a rising edge on step_up adds the increment to dac_code, saturating at 1023.
- R7: With mode_step high, a rising edge on step_dn subtracts the decrement from dac_code, saturating at 0.
- R8: With mode_step high, step_up and step_dn edges seen in the same cycle cancel each other, a held level gives no further steps, and without edges the code holds. Entering step mode keeps the code that was last loaded.
- R9: The select pair decodes as follows, written as (dac_src_sel, dac_mon_sel). (0,0) gives every output low. (1,0) gives dac_en and atten_dac. (0,1) gives dac_en and cmp_sel. (1,1) gives dac_en, atten_dac and pin_drive.
- R10: Reset clears all registers and dac_code to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out |
| mode_step | input | 1 | 0 = direct code, 1 = pulse stepping |
| step_up | input | 1 | Increment pulse, asynchronous |
| step_dn | input | 1 | Decrement pulse, asynchronous |
| dac_src_sel | input | 1 | Select bit: DAC drives the attenuators |
| dac_mon_sel | input | 1 | Select bit: DAC enabled for monitoring or test |
| dac_code | output | 10 | Code to the control DAC |
| dac_en | output | 1 | DAC enable |
| atten_dac | output | 1 | Attenuators steered from the DAC |
| cmp_sel | output | 1 | Comparator compares DAC against the control pin |
| pin_drive | output | 1 | DAC voltage driven onto the control pin |

## Verification
The step path is tried with single increments that stay in range, repeated increments that hit the top rail, and decrements large enough to cross zero. These separate plain addition from saturation at each end. Pulses arriving together, and pulses in direct mode, show whether edges are gated correctly rather than simply counted. Frames of 12, 13 and 14 bits, writes to the read-only address, and reads after writes show whether commits depend on the exact frame length and on the address decode. All four select pairs are applied to cover the decode table.

// File: rtl/att_dac_pkg.sv
package att_dac_pkg;
  typedef enum logic [1:0] {
    REG_DIRECT = 2'd0,
    REG_INC    = 2'd1,
    REG_DEC    = 2'd2,
    REG_LIVE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic en;
    logic atten;
    logic cmp;
    logic drive;
  } route_t;
endpackage

// File: rtl/att_sync.sv
module att_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= rst_val;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[N-1];
endmodule

// File: rtl/att_spi_regs.sv
module att_spi_regs
  import att_dac_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  input  logic [CODE_W-1:0] live_code,
  output logic [CODE_W-1:0] dir_code,
  output logic [CODE_W-1:0] inc_step,
  output logic [CODE_W-1:0] dec_step
);
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = 1 + ADDR_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_DAT0 = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_DATN = CNT_W'(FRAME_W - 1);

  logic s_sclk, s_csn, s_mosi;
  logic sclk_d, csn_d;
  logic [FRAME_W-1:0] frame_q, frame_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic [CODE_W-1:0]  rd_sh;
  logic               miso_q;
  logic sclk_rise, sclk_fall, cs_rise;

  att_sync #(.W(3), .N(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_val(3'b010),
    .d      ({sclk, csn, mosi}),
    .q      ({s_sclk, s_csn, s_mosi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      csn_d  <= s_csn;
    end
  end

  assign sclk_rise = s_sclk & ~sclk_d & ~s_csn;
  assign sclk_fall = ~s_sclk & sclk_d & ~s_csn;
  assign cs_rise   = s_csn & ~csn_d;
  assign frame_nx  = {frame_q[FRAME_W-2:0], s_mosi};

  function automatic logic [CODE_W-1:0] pick(input logic [ADDR_W-1:0] a,
      input logic [CODE_W-1:0] r0, input logic [CODE_W-1:0] r1,
      input logic [CODE_W-1:0] r2, input logic [CODE_W-1:0] r3);
    case (reg_addr_e'(a))
      REG_DIRECT: pick = r0;
      REG_INC:    pick = r1;
      REG_DEC:    pick = r2;
      default:    pick = r3;
    endcase
  endfunction

  // shift path, bit counter and read serializer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cnt_q   <= '0;
      rd_sh   <= '0;
      miso_q  <= 1'b0;
    end else if (s_csn) begin
      cnt_q  <= '0;
      miso_q <= 1'b0;
    end else begin
      if (sclk_rise) begin
        frame_q <= frame_nx;
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_HDR)
          rd_sh <= frame_nx[ADDR_W] ?
                   pick(frame_nx[ADDR_W-1:0], dir_code, inc_step, dec_step, live_code) : '0;
      end
      if (sclk_fall && cnt_q >= CNT_DAT0 && cnt_q <= CNT_DATN) begin
        miso_q <= rd_sh[CODE_W-1];
        rd_sh  <= {rd_sh[CODE_W-2:0], 1'b0};
      end
    end
  end

  // register commit on chip-select release (R2, R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_code <= '0;
      inc_step <= '0;
      dec_step <= '0;
    end else if (cs_rise && cnt_q == CNT_FULL && !frame_q[FRAME_W-1]) begin
      case (reg_addr_e'(frame_q[CODE_W +: ADDR_W]))
        REG_DIRECT: dir_code <= frame_q[CODE_W-1:0];
        REG_INC:    inc_step <= frame_q[CODE_W-1:0];
        REG_DEC:    dec_step <= frame_q[CODE_W-1:0];
        default:    ;
      endcase
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/att_step_engine.sv
module att_step_engine #(
  parameter int CODE_W = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_step,
  input  logic              up_raw,
  input  logic              dn_raw,
  input  logic [CODE_W-1:0] dir_code,
  input  logic [CODE_W-1:0] inc_step,
  input  logic [CODE_W-1:0] dec_step,
  output logic [CODE_W-1:0] code,
  output logic              up_edge,
  output logic              dn_edge
);
  logic s_up, s_dn, up_d, dn_d;
  logic [CODE_W:0]   sum, dif;
  logic [CODE_W-1:0] up_val, dn_val;

  att_sync #(.W(2), .N(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_val(2'b00),
    .d      ({up_raw, dn_raw}),
    .q      ({s_up, s_dn})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_d <= 1'b0;
      dn_d <= 1'b0;
    end else begin
      up_d <= s_up;
      dn_d <= s_dn;
    end
  end

  assign up_edge = s_up & ~up_d;
  assign dn_edge = s_dn & ~dn_d;

  assign sum    = {1'b0, code} + {1'b0, inc_step};
  assign dif    = {1'b0, code} - {1'b0, dec_step};
  assign up_val = sum[CODE_W] ? {CODE_W{1'b1}} : sum[CODE_W-1:0];
  assign dn_val = dif[CODE_W] ? '0 : dif[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  code <= '0;
    else if (!mode_step)         code <= dir_code;
    else if (up_edge && !dn_edge) code <= up_val;
    else if (dn_edge && !up_edge) code <= dn_val;
  end
endmodule

// File: rtl/att_route_decode.sv
module att_route_decode
  import att_dac_pkg::*;
(
  input  logic   src_sel,
  input  logic   mon_sel,
  output route_t route
);
  always_comb begin
    route = '0;
    unique case ({src_sel, mon_sel})
      2'b00: route = '0;
      2'b10: begin route.en = 1'b1; route.atten = 1'b1; end
      2'b01: begin route.en = 1'b1; route.cmp = 1'b1; end
      2'b11: begin route.en = 1'b1; route.atten = 1'b1; route.drive = 1'b1; end
      default: route = '0;
    endcase
  end
endmodule

// File: rtl/att_dac_ctrl.sv
module att_dac_ctrl
  import att_dac_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              mode_step,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              dac_src_sel,
  input  logic              dac_mon_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_en,
  output logic              atten_dac,
  output logic              cmp_sel,
  output logic              pin_drive
);
  logic [CODE_W-1:0] dir_code, inc_step, dec_step;
  logic              up_edge, dn_edge, miso_int;
  route_t            route;

  att_spi_regs #(.CODE_W(CODE_W), .SYNC_N(SYNC_N)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (spi_sclk),
    .csn      (spi_csn),
    .mosi     (spi_mosi),
    .miso     (miso_int),
    .live_code(dac_code),
    .dir_code (dir_code),
    .inc_step (inc_step),
    .dec_step (dec_step)
  );

  att_step_engine #(.CODE_W(CODE_W), .SYNC_N(SYNC_N)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_step(mode_step),
    .up_raw   (step_up),
    .dn_raw   (step_dn),
    .dir_code (dir_code),
    .inc_step (inc_step),
    .dec_step (dec_step),
    .code     (dac_code),
    .up_edge  (up_edge),
    .dn_edge  (dn_edge)
  );

  att_route_decode u_route (
    .src_sel(dac_src_sel),
    .mon_sel(dac_mon_sel),
    .route  (route)
  );

  assign spi_miso  = miso_int & ~spi_csn;
  assign dac_en    = route.en;
  assign atten_dac = route.atten;
  assign cmp_sel   = route.cmp;
  assign pin_drive = route.drive;
endmodule

// File: rtl/att_dac_ctrl_chk.sv
module att_dac_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_step,
  input logic              up_edge,
  input logic              dn_edge,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] dir_code,
  input logic              src_sel,
  input logic              mon_sel,
  input logic              dac_en,
  input logic              atten_dac,
  input logic              cmp_sel,
  input logic              pin_drive,
  input logic              spi_csn,
  input logic              spi_miso
);
  a_r5_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_step |=> dac_code == $past(dir_code));

  a_r8_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_step && !up_edge && !dn_edge) |=> $stable(dac_code));

  a_r8_both_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_step && up_edge && dn_edge) |=> $stable(dac_code));

  a_r6_up_not_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_step && up_edge && !dn_edge) |=> dac_code >= $past(dac_code));

  a_r7_dn_not_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_step && dn_edge && !up_edge) |=> dac_code <= $past(dac_code));

  a_r9_cmp_route: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_sel |-> (dac_en && !atten_dac && !pin_drive && mon_sel && !src_sel));

  a_r9_pin_route: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive |-> (dac_en && atten_dac && src_sel && mon_sel));

  a_r4_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_miso);
endmodule

bind att_dac_ctrl att_dac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_step(mode_step),
  .up_edge  (up_edge),
  .dn_edge  (dn_edge),
  .dac_code (dac_code),
  .dir_code (dir_code),
  .src_sel  (dac_src_sel),
  .mon_sel  (dac_mon_sel),
  .dac_en   (dac_en),
  .atten_dac(atten_dac),
  .cmp_sel  (cmp_sel),
  .pin_drive(pin_drive),
  .spi_csn  (spi_csn),
  .spi_miso (spi_miso)
);

// File: tb/att_dac_ctrl_tb_top.sv
`timescale 1ns/1ps
module att_dac_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic mode = 1'b0, up = 1'b0, dn = 1'b0, src = 1'b0, mon = 1'b0;
  logic [9:0] code;
  logic en, att, cmp, drv;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  att_dac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .mode_step(mode), .step_up(up), .step_dn(dn),
    .dac_src_sel(src), .dac_mon_sel(mon), .dac_code(code), .dac_en(en),
    .atten_dac(att), .cmp_sel(cmp), .pin_drive(drv)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // word is right-aligned; bit nbits-1 goes first
  task automatic spi_frame(input logic [15:0] word, input int nbits, output logic [9:0] rd);
    rd = '0;
    csn = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = word[nbits-1-i];
      #40;
      if (i >= 3 && i <= 12) rd = {rd[8:0], miso};
      sclk = 1'b1;
      #40;
    end
    sclk = 1'b0;
    #40;
    csn = 1'b1;
    #100;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    logic [9:0] junk;
    spi_frame({3'b000, 1'b0, a, d}, 13, junk);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [9:0] d);
    spi_frame({3'b000, 1'b1, a, 10'h000}, 13, d);
  endtask

  task automatic pulse(input bit u, input bit d);
    up = u; dn = d;
    #30;
    up = 1'b0; dn = 1'b0;
    #30;
  endtask

  task automatic t_reset;
    logic [9:0] v;
    chk("R10 code after reset", code, 0);
    chk("R9 en after reset (0,0)", {en, att, cmp, drv}, 0);
    chk("R4 miso idle", miso, 0);
    rd_reg(2'd1, v); chk("R10 inc reg reset", v, 0);
    rd_reg(2'd2, v); chk("R10 dec reg reset", v, 0);
  endtask

  task automatic t_write_read;
    logic [9:0] v;
    wr(2'd0, 10'h2A5);
    chk("R5 code follows direct reg", code, 10'h2A5);
    rd_reg(2'd0, v); chk("R1 R4 read direct", v, 10'h2A5);
    wr(2'd1, 10'd20);
    wr(2'd2, 10'd600);
    rd_reg(2'd1, v); chk("R3 read inc", v, 20);
    rd_reg(2'd2, v); chk("R3 read dec", v, 600);
    rd_reg(2'd3, v); chk("R3 read live code", v, 10'h2A5);
    rd_reg(2'd0, v); chk("R4 read leaves reg", v, 10'h2A5);
    chk("R4 miso low after frame", miso, 0);
  endtask

  task automatic t_bad_len;
    logic [9:0] v, junk;
    spi_frame({4'b0000, 2'd1, 10'd333} >> 1, 12, junk);
    rd_reg(2'd1, v); chk("R2 12-bit frame dropped", v, 20);
    spi_frame({2'b00, 1'b0, 2'd1, 10'd333, 1'b1}, 14, junk);
    rd_reg(2'd1, v); chk("R2 14-bit frame dropped", v, 20);
    wr(2'd3, 10'd77);
    rd_reg(2'd3, v); chk("R3 live reg write ignored", v, 10'h2A5);
    chk("R3 code unchanged by addr3 write", code, 10'h2A5);
  endtask

  task automatic t_mode0_ignore;
    wr(2'd0, 10'd1000);
    pulse(1, 0);
    chk("R5 up ignored in direct mode", code, 1000);
    pulse(0, 1);
    chk("R5 dn ignored in direct mode", code, 1000);
  endtask

  task automatic t_step;
    mode = 1'b1; #50;
    chk("R8 code kept on mode entry", code, 1000);
    pulse(1, 0); chk("R6 up adds inc", code, 1020);
    pulse(1, 0); chk("R6 up saturates 1023", code, 1023);
    pulse(1, 1); chk("R8 both edges cancel", code, 1023);
    up = 1'b1; #100;
    chk("R8 held level one step only", code, 1023);
    up = 1'b0; #50;
    pulse(0, 1); chk("R7 dn subtracts dec", code, 423);
    pulse(0, 1); chk("R7 dn saturates 0", code, 0);
    wr(2'd0, 10'd9);
    chk("R8 direct write no effect in step mode", code, 0);
    mode = 1'b0; #50;
    chk("R5 direct resumes", code, 9);
  endtask

  task automatic t_route;
    src = 0; mon = 0; #5; chk("R9 state 00", {en, att, cmp, drv}, 4'b0000);
    src = 1; mon = 0; #5; chk("R9 state 10", {en, att, cmp, drv}, 4'b1100);
    src = 0; mon = 1; #5; chk("R9 state 01", {en, att, cmp, drv}, 4'b1010);
    src = 1; mon = 1; #5; chk("R9 state 11", {en, att, cmp, drv}, 4'b1101);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1'b1;
    #50;
    t_reset;
    t_write_read;
    t_bad_len;
    t_mode0_ignore;
    t_step;
    t_route;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule